// File: doc/BRIEF.md
# DRAM Bank Row-State Sequencer

This block sits between a request source and one rank of DRAM. For every bank it remembers whether a row is latched in the bank's row buffer and, if so, which row. Requests arrive one at a time with a bank index, row, column and a read/write flag. Each request is sorted into one of three classes: the wanted row is already open, the bank is precharged, or another row is open. The block then issues the matching precharge, row-activate and column commands, and pulses `done` in the cycle the data would reach the pins. The pulse carries the class.

`page_open` picks the page policy for each request at the moment it is accepted. With open-page policy the row stays latched, so a later access to that row is cheap. With closed-page policy the bank is precharged right after the access, so later accesses find it empty. A free-running interval timer marks refresh as due. The block finishes any access in flight, precharges all banks if any row is open, and then holds a refresh window during which no request is accepted. All phase lengths are parameters counted in clock cycles.

Top module: `dpc_page_ctrl`

## Requirements
- R1: At the `done` pulse, `done_class` reports the class found when the request was accepted: 0 = open row matches (hit), 1 = bank precharged (empty), 2 = a different row is open (conflict). Code 3 never appears.
- R2: A hit issues its column command (read = 2, write = 3 on `cmd_kind`) in the first cycle after acceptance. `done` is high in cycle T_XFER after acceptance.
- R3: An empty access issues activate (`cmd_kind` = 1) in cycle 1 and its column command in cycle 2, always back to back. `done` is high in cycle T_ACT+T_XFER.
- R4: A conflict issues precharge (`cmd_kind` = 4) to the bank in cycle 1, activate in cycle T_PRE+1 and the column command in cycle T_PRE+2. `done` is high in cycle T_PRE+T_ACT+T_XFER.
- R5: Only one request is handled at a time. `req_ready` falls after acceptance and stays low until the access, and any close precharge, is over. Every command carries the request's bank, row and column, and `req_write` selects write over read.
- R6: With open-page policy the row stays open after the access, and each bank keeps its own row independently of the others.
- R7: With closed-page policy the cycle after `done` carries a precharge to that bank, and the bank is empty for its next access. The policy is sampled when the request is accepted.
- R8: Refresh falls due every T_REFI cycles. Once it is due, `req_ready` stays low. A refresh never starts while an access is in flight, and a due refresh is not lost.
- R9: A refresh issues precharge-all (`cmd_kind` = 5) for T_PRE cycles only if some row is open, then refresh (`cmd_kind` = 6) for T_RFC cycles. `refresh_busy` is high for exactly that span, no activate or column command appears during it, and afterwards every bank is empty.
- R10: After reset `req_ready` is high, and `cmd_valid`, `done` and `refresh_busy` are low, with all banks empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_open | input | 1 | 1 = open-page, 0 = closed-page policy for the next accepted request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | A DRAM command is issued this cycle |
| cmd_kind | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh |
| cmd_bank | output | clog2(NUM_BANKS) | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| done | output | 1 | One-cycle pulse when data would be at the pins |
| done_class | output | 2 | Access class, valid with `done` |
| refresh_busy | output | 1 | Refresh window (including precharge-all) active |

## Verification
The stimulus first repeats one row on one bank, which must give hits. It then walks every bank with a fresh row, which must give empty accesses, and alternates rows within a bank, which must give conflicts. The three classes are told apart by latency and by where precharge and activate fall. Closed-page runs cover a row that open-page left open: the first access still hits, and the next access to that row finds the bank empty. A long deterministic mix of banks, rows and policies crosses many refresh intervals, so refresh must wait for an access in flight. Idle gaps let refresh run with no open row, which separates the refresh-only window from the precharge-all-then-refresh window.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_EMPTY    = 2'd1,
        CLS_CONFLICT = 2'd2
    } acc_class_e;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCESS  = 3'd1,
        ST_CLOSE   = 3'd2,
        ST_REF_PRE = 3'd3,
        ST_REF_RUN = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dpc_bank_table.sv
module dpc_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    output logic              lk_open,
    output logic [ROW_W-1:0]  lk_row,
    output logic              any_open,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank,
    input  logic              clr_all
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } entry_t;

    logic [NUM_BANKS-1:0]            open_vec;
    logic [NUM_BANKS-1:0][ROW_W-1:0] row_vec;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (set_en && set_bank == BANK_W'(g)) begin
                ent_d.open = 1'b1;
                ent_d.row  = set_row;
            end
            if (clr_all || (clr_en && clr_bank == BANK_W'(g))) begin
                ent_d.open = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign open_vec[g] = ent_q.open;
        assign row_vec[g]  = ent_q.row;
    end

    assign lk_open  = open_vec[lk_bank];
    assign lk_row   = row_vec[lk_bank];
    assign any_open = |open_vec;

endmodule

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
    parameter int T_REFI = 7800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);

    localparam int CW = $clog2(T_REFI);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;

    always_comb begin
        t_d   = t_q;
        tick  = (t_q.cnt == CW'(T_REFI - 1));
        t_d.cnt = tick ? '0 : t_q.cnt + CW'(1);
        if (ack)  t_d.pend = 1'b0;
        if (tick) t_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pending = t_q.pend;

endmodule

// File: rtl/dpc_sequencer.sv
module dpc_sequencer
    import dpc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int T_XFER    = 20,
    parameter int T_ACT     = 20,
    parameter int T_PRE     = 20,
    parameter int T_RFC     = 160,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_open,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              lk_open,
    input  logic [ROW_W-1:0]  lk_row,
    input  logic              any_open,
    output logic              set_en,
    output logic              clr_en,
    output logic              clr_all,
    output logic [BANK_W-1:0] cur_bank,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done,
    output logic [1:0]        done_class,
    output logic              refresh_busy
);

    localparam int LAT_MAX = T_PRE + T_ACT + T_XFER;
    localparam int SPAN    = (LAT_MAX > T_RFC) ? LAT_MAX : T_RFC;
    localparam int CNT_W   = $clog2(SPAN + 2);

    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(T_PRE);
    localparam logic [CNT_W-1:0] C_RFC  = CNT_W'(T_RFC);
    localparam logic [CNT_W-1:0] C_HIT  = CNT_W'(T_XFER);
    localparam logic [CNT_W-1:0] C_EMP  = CNT_W'(T_ACT + T_XFER);
    localparam logic [CNT_W-1:0] C_CON  = CNT_W'(T_PRE + T_ACT + T_XFER);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  el;
        acc_class_e        cls;
        logic              closed;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } seq_t;

    seq_t             s_d, s_q;
    cmd_e             cmd;
    acc_class_e       cls_new;
    logic             accept;
    logic [CNT_W-1:0] total, act_at, cas_at;

    // Phase positions, counted from the first cycle after acceptance.
    always_comb begin
        unique case (s_q.cls)
            CLS_HIT: begin
                total  = C_HIT;
                act_at = '0;
                cas_at = C_ONE;
            end
            CLS_EMPTY: begin
                total  = C_EMP;
                act_at = C_ONE;
                cas_at = C_ONE + C_ONE;
            end
            default: begin
                total  = C_CON;
                act_at = C_PRE + C_ONE;
                cas_at = C_PRE + C_ONE + C_ONE;
            end
        endcase
    end

    always_comb begin
        cls_new = !lk_open            ? CLS_EMPTY :
                  (lk_row == req_row) ? CLS_HIT   : CLS_CONFLICT;
        req_ready = (s_q.st == ST_IDLE) && !ref_pending;
        accept    = req_ready && req_valid;

        s_d     = s_q;
        cmd     = CMD_NOP;
        set_en  = 1'b0;
        clr_en  = 1'b0;
        clr_all = 1'b0;
        ref_ack = 1'b0;
        done    = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_ack = 1'b1;
                    s_d.el  = C_ONE;
                    s_d.st  = any_open ? ST_REF_PRE : ST_REF_RUN;
                end else if (accept) begin
                    set_en     = 1'b1;
                    s_d.st     = ST_ACCESS;
                    s_d.el     = C_ONE;
                    s_d.cls    = cls_new;
                    s_d.closed = !page_open;
                    s_d.wr     = req_write;
                    s_d.bank   = req_bank;
                    s_d.row    = req_row;
                    s_d.col    = req_col;
                end
            end
            ST_ACCESS: begin
                if (s_q.cls == CLS_CONFLICT && s_q.el == C_ONE) cmd = CMD_PRE;
                if (s_q.cls != CLS_HIT && s_q.el == act_at)     cmd = CMD_ACT;
                if (s_q.el == cas_at) cmd = s_q.wr ? CMD_WR : CMD_RD;
                if (s_q.el == total) begin
                    done   = 1'b1;
                    s_d.el = C_ONE;
                    s_d.st = s_q.closed ? ST_CLOSE : ST_IDLE;
                end else begin
                    s_d.el = s_q.el + C_ONE;
                end
            end
            ST_CLOSE: begin
                if (s_q.el == C_ONE) begin
                    cmd    = CMD_PRE;
                    clr_en = 1'b1;
                end
                if (s_q.el >= C_PRE) s_d.st = ST_IDLE;
                else                 s_d.el = s_q.el + C_ONE;
            end
            ST_REF_PRE: begin
                if (s_q.el == C_ONE) begin
                    cmd     = CMD_PREA;
                    clr_all = 1'b1;
                end
                if (s_q.el >= C_PRE) begin
                    s_d.st = ST_REF_RUN;
                    s_d.el = C_ONE;
                end else begin
                    s_d.el = s_q.el + C_ONE;
                end
            end
            ST_REF_RUN: begin
                if (s_q.el == C_ONE) begin
                    cmd     = CMD_REF;
                    clr_all = 1'b1;
                end
                if (s_q.el >= C_RFC) s_d.st = ST_IDLE;
                else                 s_d.el = s_q.el + C_ONE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_bank     = s_q.bank;
    assign cmd_kind     = cmd;
    assign cmd_valid    = (cmd != CMD_NOP);
    assign cmd_bank     = s_q.bank;
    assign cmd_row      = s_q.row;
    assign cmd_col      = s_q.col;
    assign done_class   = s_q.cls;
    assign refresh_busy = (s_q.st == ST_REF_PRE) || (s_q.st == ST_REF_RUN);

endmodule

// File: rtl/dpc_page_ctrl.sv
module dpc_page_ctrl #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int T_XFER    = 20,
    parameter int T_ACT     = 20,
    parameter int T_PRE     = 20,
    parameter int T_RFC     = 160,
    parameter int T_REFI    = 7800,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_open,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done,
    output logic [1:0]        done_class,
    output logic              refresh_busy
);

    logic              lk_open, any_open;
    logic [ROW_W-1:0]  lk_row;
    logic              set_en, clr_en, clr_all;
    logic [BANK_W-1:0] cur_bank;
    logic              ref_pending, ref_ack;

    dpc_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (req_bank),
        .lk_open  (lk_open),
        .lk_row   (lk_row),
        .any_open (any_open),
        .set_en   (set_en),
        .set_bank (req_bank),
        .set_row  (req_row),
        .clr_en   (clr_en),
        .clr_bank (cur_bank),
        .clr_all  (clr_all)
    );

    dpc_refresh_timer #(
        .T_REFI (T_REFI)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    dpc_sequencer #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .T_XFER    (T_XFER),
        .T_ACT     (T_ACT),
        .T_PRE     (T_PRE),
        .T_RFC     (T_RFC),
        .BANK_W    (BANK_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_open    (page_open),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_write    (req_write),
        .lk_open      (lk_open),
        .lk_row       (lk_row),
        .any_open     (any_open),
        .set_en       (set_en),
        .clr_en       (clr_en),
        .clr_all      (clr_all),
        .cur_bank     (cur_bank),
        .ref_pending  (ref_pending),
        .ref_ack      (ref_ack),
        .cmd_valid    (cmd_valid),
        .cmd_kind     (cmd_kind),
        .cmd_bank     (cmd_bank),
        .cmd_row      (cmd_row),
        .cmd_col      (cmd_col),
        .done         (done),
        .done_class   (done_class),
        .refresh_busy (refresh_busy)
    );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
    import dpc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] cmd_kind,
    input logic       done,
    input logic [1:0] done_class,
    input logic       refresh_busy
);

    p_class_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_class != 2'd3));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_act_then_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_ACT) |=> (cmd_kind == CMD_RD || cmd_kind == CMD_WR));

    p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_refresh_blocks_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> !req_ready);

    p_no_access_in_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> !(cmd_kind == CMD_ACT || cmd_kind == CMD_RD || cmd_kind == CMD_WR));

    p_ref_inside_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_REF || cmd_kind == CMD_PREA) |-> refresh_busy);

    p_no_done_in_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |-> !done);

endmodule

bind dpc_page_ctrl dpc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .cmd_kind     (cmd_kind),
    .done         (done),
    .done_class   (done_class),
    .refresh_busy (refresh_busy)
);

// File: tb/sim_dpc_page_ctrl.sv
module sim_dpc_page_ctrl;
    import dpc_pkg::*;

    localparam int NB  = 8;
    localparam int RW  = 14;
    localparam int CW  = 10;
    localparam int TX  = 4;
    localparam int TA  = 3;
    localparam int TP  = 2;
    localparam int TR  = 6;
    localparam int TI  = 300;
    localparam int BW  = $clog2(NB);
    localparam int WIN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          page_open = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic          req_ready, cmd_valid, done, refresh_busy;
    logic [2:0]    cmd_kind;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic [1:0]    done_class;

    always #2 clk = ~clk;

    dpc_page_ctrl #(
        .NUM_BANKS (NB), .ROW_W (RW), .COL_W (CW),
        .T_XFER (TX), .T_ACT (TA), .T_PRE (TP), .T_RFC (TR), .T_REFI (TI)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .page_open (page_open),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .req_write (req_write),
        .cmd_valid (cmd_valid), .cmd_kind (cmd_kind), .cmd_bank (cmd_bank),
        .cmd_row (cmd_row), .cmd_col (cmd_col),
        .done (done), .done_class (done_class), .refresh_busy (refresh_busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        int bank; int row; int col; int cls; int acc; bit wr; bit closed;
    } exp_t;
    exp_t sbq[$];

    bit m_open[NB];
    int m_row[NB];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string cls_tag(input int c);
        return (c == 0) ? "R2" : (c == 1) ? "R3" : "R4";
    endfunction

    function automatic int exp_lat(input int c);
        return (c == 0) ? TX : (c == 1) ? TA + TX : TP + TA + TX;
    endfunction

    // Driver: predicts the class from its own row model and queues the expectation.
    task automatic access(input int b, input int r, input bit wr);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.bank = b; e.row = r; e.col = (b * 7 + r * 3) % 1024; e.wr = wr;
        e.closed = !page_open;
        e.cls = !m_open[b] ? 1 : ((m_row[b] == r) ? 0 : 2);
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_col   = CW'(e.col);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        e.acc = cyc;
        sbq.push_back(e);
        m_open[b] = !e.closed;
        m_row[b]  = r;
    endtask

    // Monitor state
    bit close_exp = 0;
    int close_due = 0;
    int close_bank = 0;
    bit busy_prev = 0;
    int rise_cyc = 0;
    int last_rise = -1;
    bit used_prea = 0;
    int last_act = -10;
    int n_ref = 0;
    int rel_cyc = 0;
    int rel, ex, lat;
    bit any;
    exp_t e;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (close_exp && cyc == close_due) begin
                check(cmd_kind == CMD_PRE && int'(cmd_bank) == close_bank, "R7",
                      "close precharge kind", int'(cmd_kind), int'(CMD_PRE));
                close_exp = 0;
            end
            if (cmd_valid && sbq.size() > 0) begin
                rel = cyc - sbq[0].acc + 1;
                if (cmd_kind == CMD_PRE) begin
                    check(sbq[0].cls == 2 && rel == 1 && int'(cmd_bank) == sbq[0].bank,
                          "R4", "precharge cycle", rel, 1);
                end else if (cmd_kind == CMD_ACT) begin
                    ex = (sbq[0].cls == 2) ? TP + 1 : 1;
                    check(rel == ex && int'(cmd_bank) == sbq[0].bank && int'(cmd_row) == sbq[0].row,
                          (sbq[0].cls == 2) ? "R4" : "R3", "activate cycle", rel, ex);
                    last_act = cyc;
                end else if (cmd_kind == CMD_RD || cmd_kind == CMD_WR) begin
                    ex = (sbq[0].cls == 0) ? 1 : (sbq[0].cls == 1) ? 2 : TP + 2;
                    check(rel == ex, cls_tag(sbq[0].cls), "column cycle", rel, ex);
                    check(cmd_kind == (sbq[0].wr ? CMD_WR : CMD_RD) &&
                          int'(cmd_bank) == sbq[0].bank && int'(cmd_col) == sbq[0].col,
                          "R5", "column command fields", int'(cmd_kind),
                          int'(sbq[0].wr ? CMD_WR : CMD_RD));
                    if (sbq[0].cls != 0)
                        check(last_act == cyc - 1, "R3", "activate-column spacing",
                              cyc - last_act, 1);
                end else begin
                    check(0, "R8", "refresh command during access", int'(cmd_kind), 0);
                end
            end
            if (done) begin
                if (sbq.size() == 0) begin
                    check(0, "R5", "done with no access", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    lat = cyc - e.acc + 1;
                    check(int'(done_class) == e.cls, "R1", "access class",
                          int'(done_class), e.cls);
                    check(lat == exp_lat(e.cls), cls_tag(e.cls), "done latency",
                          lat, exp_lat(e.cls));
                    if (e.closed) begin
                        close_exp  = 1;
                        close_due  = cyc + 1;
                        close_bank = e.bank;
                    end
                end
            end
            if (refresh_busy && !busy_prev) begin
                any = 0;
                for (int b = 0; b < NB; b++) any |= m_open[b];
                check(cmd_kind == (any ? CMD_PREA : CMD_REF), "R9", "refresh first command",
                      int'(cmd_kind), int'(any ? CMD_PREA : CMD_REF));
                check(sbq.size() == 0, "R8", "refresh started with access in flight",
                      sbq.size(), 0);
                if (last_rise >= 0)
                    check(cyc - last_rise >= TI - WIN && cyc - last_rise <= TI + WIN,
                          "R8", "refresh spacing", cyc - last_rise, TI);
                else
                    check(cyc - rel_cyc >= TI - WIN && cyc - rel_cyc <= TI + WIN,
                          "R8", "first refresh time", cyc - rel_cyc, TI);
                used_prea = any;
                rise_cyc  = cyc;
                last_rise = cyc;
                n_ref++;
                for (int b = 0; b < NB; b++) m_open[b] = 0;
            end
            if (refresh_busy && cyc == rise_cyc + (used_prea ? TP : 0))
                check(cmd_kind == CMD_REF, "R9", "refresh command position",
                      int'(cmd_kind), int'(CMD_REF));
            if (!refresh_busy && busy_prev)
                check(cyc - rise_cyc == (used_prea ? TP : 0) + TR, "R9", "refresh window length",
                      cyc - rise_cyc, (used_prea ? TP : 0) + TR);
            if (refresh_busy && req_ready)
                check(0, "R8", "ready during refresh", 1, 0);
            busy_prev = refresh_busy;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rel_cyc = cyc;
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
        check(cmd_valid == 1'b0, "R10", "no command after reset", int'(cmd_valid), 0);
        check(done == 1'b0, "R10", "no done after reset", int'(done), 0);
        check(refresh_busy == 1'b0, "R10", "no refresh after reset", int'(refresh_busy), 0);

        // R6 open page: same row repeats hit, new row conflicts, banks independent
        page_open = 1'b1;
        access(0, 5, 0);
        access(0, 5, 0);
        access(0, 5, 1);
        access(0, 9, 0);
        for (int b = 1; b < NB; b++) access(b, 20 + b, b % 2);
        access(0, 9, 1);
        for (int b = 1; b < NB; b++) access(b, 20 + b, 0);
        access(3, 100, 1);

        // R7 closed page: left-open row still hits once, then the bank is empty
        page_open = 1'b0;
        access(0, 9, 0);
        access(0, 9, 1);
        access(5, 7, 0);
        access(5, 7, 0);
        page_open = 1'b1;
        access(5, 7, 0);
        access(5, 7, 1);

        // Long mixed run crossing several refresh intervals
        for (int i = 0; i < 240; i++) begin
            page_open = !(i >= 100 && i < 140);
            access((i * 3) % NB, 40 + (i / 5) % 3, i % 2);
        end
        page_open = 1'b1;
        while (sbq.size() > 0) @(negedge clk);

        // Idle: refreshes with and then without open rows (R9)
        repeat (3 * TI) @(negedge clk);
        access(0, 41, 0);
        access(0, 41, 0);
        while (sbq.size() > 0) @(negedge clk);
        repeat (TP + 4) @(negedge clk);

        check(n_ref >= (cyc - rel_cyc) / TI - 1, "R8", "refresh count", n_ref,
              (cyc - rel_cyc) / TI - 1);
        check(!close_exp, "R7", "close precharge still owed", int'(close_exp), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule